// File: doc/BRIEF.md
# Streaming Softmax Row Unit

The unit turns one row of signed fixed-point scores into softmax probabilities. Scores arrive `LANES` elements per beat, qualified by a valid strobe, and the final beat of a row carries a last flag. While a row streams in, its scores are parked in one half of a two-bank score store, and a comparator reduction keeps a running maximum. When the last beat closes the row, an exponent pass reads the stored beats back one per cycle. It subtracts each score from the row maximum, looks the non-negative difference up in a computed exponent table, reduces each beat to a partial sum and accumulates the row total. The exponent values go into one half of a two-bank row buffer.

Once the total is known, a divide pass reads the buffered exponents and produces `LANES` normalised outputs per beat through parallel dividers. The three passes work on consecutive rows at the same time, so rows may arrive back to back without a gap. Each output is unsigned with all bits fractional: code 256 would mean 1.0, and codes saturate at 255. Element order within a row is beat order first, then lane order, with lane 0 in the least significant bits.

Top module: `softmax_row_unit`

## Requirements
- R1: After reset is released, and until the first row's output is due, `out_valid_o` is low.
- R2: The exponent of an element with difference d = (row maximum − score), in input LSBs, is T[d] for d < 32 and 0 for d ≥ 32. T[0] = 65536 (1.0 with 16 fractional bits) and T[k] = floor(T[k−1]·51039/65536).
- R3: Each output equals min(255, floor(e·256/S)), where e is that element's exponent and S is the sum of the exponents of all 16 elements in the row.
- R4: A row of 16 equal scores yields 16 (that is, 1/16) on every element.
- R5: The output beats of a row appear on consecutive cycles. Beat j (0 to 3) is valid in the cycle that follows clock edge E+5+j, where E is the edge that accepts the row's last input beat. `out_last_o` is high only on beat 3.
- R6: Rows sent back to back, with no idle cycle between them, are all produced in arrival order, each with its own correct values.
- R7: Input cycles with `in_valid_i` low change no state, whatever `in_data_i` and `in_last_i` carry. A row spread out with idle gaps gives the same outputs as the same row sent without gaps.
- R8: The row maximum spans all lanes and all beats of the row. An element equal to the maximum gets exponent 1.0, and a single dominant element whose rivals all lie 32 or more LSBs below it gives 255, while the rivals give 0.
- R9: Each row is exactly 4 beats (16 elements). `in_last_i` is high on the 4th valid beat of a row and on no other beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input beat is valid |
| in_last_i | input | 1 | Valid beat is the row's final beat |
| in_data_i | input | 32 | Four signed 8-bit scores, lane 0 in bits 7:0 |
| out_valid_o | output | 1 | Output beat is valid |
| out_last_o | output | 1 | Output beat is the row's final beat |
| out_data_o | output | 32 | Four unsigned 8-bit probabilities, lane 0 in bits 7:0 |

## Verification
The hardest condition to reach is full overlap. In that state a new row is being stored in one score bank, the previous row's exponents are being accumulated from the other bank, and the row before that is being divided out of the exponent buffer, all in the same cycle. The bank hand-overs then fall on the same clock edge as the next row's closing beat. The stimulus reaches this by sending several rows with no idle cycle between them. It also sends rows with idle gaps that carry random junk data, and shaped rows: all-equal scores, a single dominant score, and differences of exactly 31 and 32 LSBs around the edge of the table. A behavioural model predicts the cycle and value of every output beat, and each clock is compared against it.

// File: rtl/sm_pkg.sv
package sm_pkg;
  // exp(-0.25) in Q0.16: one table step per input LSB (inputs carry 2 fractional bits)
  localparam longint EXP_STEP_Q16 = 51039;

  function automatic longint exp_next(input longint v);
    return (v * EXP_STEP_Q16) >>> 16;
  endfunction
endpackage

// File: rtl/sm_max_tree.sv
module sm_max_tree #(
  parameter int LANES = 4,
  parameter int IN_W  = 8
) (
  input  logic signed [IN_W-1:0] vals_i [LANES],
  output logic signed [IN_W-1:0] max_o
);
  localparam int LVLS = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int PADN = 1 << LVLS;

  logic signed [IN_W-1:0] node [LVLS+1][PADN];

  // level 0 padded with the first lane so padding never wins
  for (genvar i = 0; i < PADN; i++) begin : g_leaf
    if (i < LANES) begin : g_real
      assign node[0][i] = vals_i[i];
    end else begin : g_pad
      assign node[0][i] = vals_i[0];
    end
  end

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    for (genvar i = 0; i < (PADN >> (l + 1)); i++) begin : g_cmp
      assign node[l+1][i] = (node[l][2*i] > node[l][2*i+1]) ? node[l][2*i] : node[l][2*i+1];
    end
    for (genvar i = (PADN >> (l + 1)); i < PADN; i++) begin : g_unused
      assign node[l+1][i] = '0;
    end
  end

  assign max_o = node[LVLS][0];
endmodule

// File: rtl/sm_exp_stage.sv
module sm_exp_stage #(
  parameter int LANES     = 4,
  parameter int IN_W      = 8,
  parameter int EXP_FRAC  = 16,
  parameter int LUT_DEPTH = 32,
  parameter int SUM_W     = 22,
  localparam int EXP_W    = EXP_FRAC + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic signed [IN_W-1:0] row_max_i,
  input  logic signed [IN_W-1:0] scores_i [LANES],
  output logic [EXP_W-1:0]       exps_o [LANES],
  output logic [SUM_W-1:0]       part_o
);
  localparam int IDX_W = (LUT_DEPTH > 1) ? $clog2(LUT_DEPTH) : 1;
  localparam logic [EXP_W-1:0] ONE = EXP_W'(1) << EXP_FRAC;

  function automatic logic [LUT_DEPTH-1:0][EXP_W-1:0] build_tab();
    logic [LUT_DEPTH-1:0][EXP_W-1:0] t;
    longint v;
    v = longint'(1) << EXP_FRAC;
    for (int k = 0; k < LUT_DEPTH; k++) begin
      t[k] = EXP_W'(v);
      v = sm_pkg::exp_next(v);
    end
    return t;
  endfunction

  localparam logic [LUT_DEPTH-1:0][EXP_W-1:0] EXP_TAB = build_tab();

  logic signed [IN_W:0] diff [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      diff[i] = {row_max_i[IN_W-1], row_max_i} - {scores_i[i][IN_W-1], scores_i[i]};
      if (diff[i] < 0 || int'(diff[i]) >= LUT_DEPTH) exps_o[i] = '0;
      else exps_o[i] = EXP_TAB[IDX_W'(diff[i])];
    end

    AST_MAX_DOMINATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |-> row_max_i >= scores_i[i]); // R8
    AST_PEAK_IS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && row_max_i == scores_i[i]) |-> exps_o[i] == ONE); // R2
  end

  always_comb begin
    part_o = '0;
    for (int i = 0; i < LANES; i++) part_o = part_o + SUM_W'(exps_o[i]);
  end
endmodule

// File: rtl/sm_div_stage.sv
module sm_div_stage #(
  parameter int LANES    = 4,
  parameter int EXP_FRAC = 16,
  parameter int SUM_W    = 22,
  parameter int OUT_W    = 8,
  localparam int EXP_W   = EXP_FRAC + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [EXP_W-1:0]   exps_i [LANES],
  input  logic [SUM_W-1:0]   sum_i,
  output logic [OUT_W-1:0]   probs_o [LANES]
);
  localparam int NUM_W = EXP_W + OUT_W;
  localparam int DW    = (NUM_W > SUM_W) ? NUM_W : SUM_W;
  localparam logic [DW-1:0] SAT = DW'((1 << OUT_W) - 1);

  for (genvar i = 0; i < LANES; i++) begin : g_div
    logic [DW-1:0] num, quo;
    always_comb begin
      num = DW'({exps_i[i], {OUT_W{1'b0}}});
      quo = (sum_i == '0) ? SAT : num / DW'(sum_i);
      probs_o[i] = (quo > SAT) ? SAT[OUT_W-1:0] : quo[OUT_W-1:0];
    end
  end

  AST_SUM_HOLDS_PEAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> sum_i >= (SUM_W'(1) << EXP_FRAC)); // R3
endmodule

// File: rtl/softmax_row_unit.sv
module softmax_row_unit #(
  parameter int LANES     = 4,
  parameter int ROW_LEN   = 16,
  parameter int IN_W      = 8,
  parameter int EXP_FRAC  = 16,
  parameter int LUT_DEPTH = 32,
  parameter int OUT_W     = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic                     in_last_i,
  input  logic [LANES*IN_W-1:0]    in_data_i,
  output logic                     out_valid_o,
  output logic                     out_last_o,
  output logic [LANES*OUT_W-1:0]   out_data_o
);
  localparam int BEATS = ROW_LEN / LANES;
  localparam int BI_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int EXP_W = EXP_FRAC + 1;
  localparam int SUM_W = EXP_W + $clog2(ROW_LEN) + 1;
  localparam logic [BI_W-1:0] LAST_BEAT = BI_W'(BEATS - 1);

  // ---------------- gather: store scores, track maximum
  logic signed [IN_W-1:0] in_lane [LANES];
  logic signed [IN_W-1:0] beat_max, run_max, new_max;
  logic signed [IN_W-1:0] score_q [2][BEATS][LANES];
  logic                   g_bank;
  logic [BI_W-1:0]        g_idx;
  logic                   row_done;

  for (genvar l = 0; l < LANES; l++) begin : g_unpack
    assign in_lane[l] = in_data_i[l*IN_W +: IN_W];
  end

  sm_max_tree #(.LANES(LANES), .IN_W(IN_W)) u_max (
    .vals_i(in_lane), .max_o(beat_max)
  );

  assign new_max  = (g_idx == '0 || beat_max > run_max) ? beat_max : run_max;
  assign row_done = in_valid_i && in_last_i;

  always_ff @(posedge clk_i) begin
    if (in_valid_i) begin
      for (int l = 0; l < LANES; l++) score_q[g_bank][g_idx][l] <= in_lane[l];
    end
  end

  // ---------------- exponent pass
  logic                   x_act, x_bank, e_bank;
  logic [BI_W-1:0]        x_idx;
  logic signed [IN_W-1:0] x_max;
  logic [EXP_W-1:0]       x_exps [LANES];
  logic [SUM_W-1:0]       x_part, acc, acc_next;
  logic [EXP_W-1:0]       ebuf_q [2][BEATS][LANES];
  logic                   x_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_bank  <= 1'b0;
      g_idx   <= '0;
      run_max <= '0;
      x_act   <= 1'b0;
      x_bank  <= 1'b0;
      x_max   <= '0;
    end else begin
      if (in_valid_i) begin
        run_max <= new_max;
        g_idx   <= in_last_i ? '0 : g_idx + 1'b1;
        if (in_last_i) g_bank <= ~g_bank;
      end
      if (row_done) begin
        x_act  <= 1'b1;
        x_bank <= g_bank;
        x_max  <= new_max;
      end else if (x_end) begin
        x_act  <= 1'b0;
      end
    end
  end

  sm_exp_stage #(
    .LANES(LANES), .IN_W(IN_W), .EXP_FRAC(EXP_FRAC),
    .LUT_DEPTH(LUT_DEPTH), .SUM_W(SUM_W)
  ) u_exp (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(x_act),
    .row_max_i(x_max), .scores_i(score_q[x_bank][x_idx]),
    .exps_o(x_exps), .part_o(x_part)
  );

  assign x_end    = x_act && (x_idx == LAST_BEAT);
  assign acc_next = (x_idx == '0) ? x_part : acc + x_part;

  always_ff @(posedge clk_i) begin
    if (x_act) begin
      for (int l = 0; l < LANES; l++) ebuf_q[e_bank][x_idx][l] <= x_exps[l];
    end
  end

  // ---------------- divide pass
  logic             d_act, d_bank, d_end;
  logic [BI_W-1:0]  d_idx;
  logic [SUM_W-1:0] d_sum;
  logic [OUT_W-1:0] d_probs [LANES];
  logic             out_valid_q, out_last_q;
  logic [LANES*OUT_W-1:0] out_data_q;

  assign d_end = d_act && (d_idx == LAST_BEAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_idx  <= '0;
      acc    <= '0;
      e_bank <= 1'b0;
      d_act  <= 1'b0;
      d_bank <= 1'b0;
      d_idx  <= '0;
      d_sum  <= '0;
    end else begin
      if (x_act) begin
        acc   <= acc_next;
        x_idx <= x_end ? '0 : x_idx + 1'b1;
      end
      if (x_end) begin
        d_act  <= 1'b1;
        d_bank <= e_bank;
        d_sum  <= acc_next;
        e_bank <= ~e_bank;
      end else if (d_end) begin
        d_act  <= 1'b0;
      end
      if (d_act) d_idx <= d_end ? '0 : d_idx + 1'b1;
    end
  end

  sm_div_stage #(
    .LANES(LANES), .EXP_FRAC(EXP_FRAC), .SUM_W(SUM_W), .OUT_W(OUT_W)
  ) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(d_act),
    .exps_i(ebuf_q[d_bank][d_idx]), .sum_i(d_sum), .probs_o(d_probs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= d_act;
      out_last_q  <= d_end;
      if (d_act) begin
        for (int l = 0; l < LANES; l++) out_data_q[l*OUT_W +: OUT_W] <= d_probs[l];
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_last_o  = out_last_q;
  assign out_data_o  = out_data_q;

  AST_LAST_ON_FINAL_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_done |-> g_idx == LAST_BEAT); // R9
  AST_FINAL_BEAT_HAS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && g_idx == LAST_BEAT) |-> in_last_i); // R9
  AST_BANKS_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_act && in_valid_i) |-> g_bank != x_bank); // R6
  AST_START_ONLY_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_done && x_act) |-> x_end); // R6
  AST_BURST_ENDS_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |-> $past(out_last_o)); // R5
  AST_LAST_IS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o); // R5
endmodule

// File: tb/softmax_row_unit_test.sv
module softmax_row_unit_test;
  localparam int LANES = 4;
  localparam int ROW   = 16;
  localparam int BEATS = ROW / LANES;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid, out_last;
  logic [31:0] out_data;

  softmax_row_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_last_i(in_last),
    .in_data_i(in_data), .out_valid_o(out_valid), .out_last_o(out_last),
    .out_data_o(out_data)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int edge_no = 0;
  string cur_tag = "R3";
  longint tab [32];

  typedef struct {
    int          due;
    logic [31:0] data;
    bit          last;
    string       tag;
  } beat_t;

  beat_t  expq [$];
  int     row_acc [$];

  // behavioural model: exponent table per R2
  initial begin
    longint v;
    v = 65536;
    for (int k = 0; k < 32; k++) begin
      tab[k] = v;
      v = (v * 51039) / 65536;
    end
  end

  task automatic model_row(input int e_edge, input string tag);
    int mx;
    longint e [ROW];
    longint s;
    longint q;
    mx = row_acc[0];
    foreach (row_acc[i]) if (row_acc[i] > mx) mx = row_acc[i];
    s = 0;
    for (int i = 0; i < ROW; i++) begin
      e[i] = (mx - row_acc[i] < 32) ? tab[mx - row_acc[i]] : 0;
      s += e[i];
    end
    for (int b = 0; b < BEATS; b++) begin
      beat_t bt;
      bt.due  = e_edge + BEATS + 1 + b;
      bt.last = (b == BEATS - 1);
      bt.tag  = tag;
      bt.data = '0;
      for (int l = 0; l < LANES; l++) begin
        q = (e[b*LANES+l] * 256) / s;
        if (q > 255) q = 255;
        bt.data[l*8 +: 8] = q[7:0];
      end
      expq.push_back(bt);
    end
    row_acc.delete();
  endtask

  // input monitor at the edge (inputs are driven at negedge)
  always @(posedge clk) begin
    edge_no++;
    if (rst_n && in_valid) begin
      for (int l = 0; l < LANES; l++) row_acc.push_back(int'($signed(in_data[l*8 +: 8])));
      if (in_last) model_row(edge_no, cur_tag);
    end
  end

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (expq.size() > 0 && expq[0].due == edge_no) begin
        total++;
        if (!out_valid) begin
          bad++;
          $display("FAIL R5 edge %0d: out_valid=%0b expected 1", edge_no, out_valid);
        end
        total++;
        if (out_data !== expq[0].data) begin
          bad++;
          $display("FAIL %s edge %0d: data=%h expected %h", expq[0].tag, edge_no, out_data, expq[0].data);
        end
        total++;
        if (out_last !== expq[0].last) begin
          bad++;
          $display("FAIL R5 edge %0d: out_last=%0b expected %0b", edge_no, out_last, expq[0].last);
        end
        void'(expq.pop_front());
      end else begin
        total++;
        if (out_valid !== 1'b0) begin
          bad++;
          $display("FAIL R5 edge %0d: out_valid=%0b expected 0", edge_no, out_valid);
        end
      end
    end
  end

  // every row carries last on its 4th valid beat (R9)
  task automatic send_row(input int v [ROW], input bit gaps, input string tag);
    cur_tag = tag;
    for (int b = 0; b < BEATS; b++) begin
      if (gaps) begin
        for (int g = 0; g < 2; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_last  = $urandom_range(0, 1);
          in_data  = $urandom;
        end
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_last  = (b == BEATS - 1);
      for (int l = 0; l < LANES; l++) in_data[l*8 +: 8] = v[b*LANES+l][7:0];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      in_data  = '0;
    end
  endtask

  initial begin
    int v [ROW];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: out_valid=%0b expected 0", out_valid);
    end

    for (int i = 0; i < ROW; i++) v[i] = 10;
    send_row(v, 0, "R4");
    idle(12);

    for (int i = 0; i < ROW; i++) v[i] = i - 8;
    send_row(v, 0, "R3");
    idle(12);

    for (int i = 0; i < ROW; i++) v[i] = -128;
    v[13] = 127;
    send_row(v, 0, "R8");
    idle(12);

    for (int i = 0; i < ROW; i++) v[i] = (i % 2) ? 9 : 8;
    v[6] = 40;
    v[15] = 39;
    send_row(v, 0, "R2");
    idle(12);

    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < ROW; i++) v[i] = int'($urandom_range(0, 40)) - 20;
      send_row(v, 0, "R6");
    end
    idle(12);

    for (int i = 0; i < ROW; i++) v[i] = int'($urandom_range(0, 60)) - 30;
    send_row(v, 1, "R7");
    send_row(v, 0, "R7");
    idle(12);

    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < ROW; i++) v[i] = int'($urandom_range(0, 255)) - 128;
      send_row(v, 0, "R3");
    end
    idle(16);

    total++;
    if (expq.size() != 0) begin
      bad++;
      $display("FAIL R5: %0d beats missing, expected 0", expq.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule